// File: doc/BRIEF.md
# Comparator Output Conditioner

This block is the digital half of an analog comparator. It receives the comparator's raw decision bit and can invert it. It then passes the bit through a glitch filter that changes its output only after a programmed number of consecutive samples agree. The samples are paced in one of two ways. An internal prescaler can pace them. An external strobe can pace them instead, after that strobe passes through a synchroniser and a rising-edge detector. The module output carries either the filtered or the unfiltered level. Two sticky flags record rising and falling edges of the filtered level, and an interrupt request is raised from whichever flags are enabled.

Software configures the block through one 32-bit control word. A single write port loads every writable field. The two edge-flag bits are write-one-to-clear, and the filtered level is visible as a read-only bit. A window input can freeze the filtered level, so that the output ignores the comparator outside an allowed time slot. The hysteresis level, power mode and output-pin enable fields are only stored and read back here. They drive the analog side, which lies outside this block.

Top module: `cmp_backend`

## Requirements
- R1: After reset the control word reads 0x0000_0000, `cmp_out` is 0 and `irq` is 0.
- R2: A write stores hysteresis [1:0], count [6:4], enable [8], pin enable [9], select [10], invert [11], power mode [12], window enable [14], strobe mode [15], period [23:16] and the interrupt enables [27] (fall) and [28] (rise). Bit 24 reads the filtered level and ignores writes. Bits 3:2, 7, 13 and 29 to 31 read 0.
- R3: When invert [11] is 1, the comparator bit is inverted before both the filter and the unfiltered path.
- R4: With enable set, select [10] = 1 drives `cmp_out` from the unfiltered (post-invert) level, and select = 0 drives it from the filtered level.
- R5: With count = 0 and strobe mode = 0, the filtered level equals the unfiltered level in the same cycle. The same holds with count nonzero, strobe mode = 0 and period = 0.
- R6: With count N in 1..7 and strobe mode = 1, a sample is taken once per rising edge of `sample_strobe` after a two-flop synchroniser. The filtered level takes a new value only after N consecutive samples equal that value.
- R7: With count N nonzero, strobe mode = 0 and period P nonzero, a sample is taken once every P+1 clocks.
- R8: With count = 0 and strobe mode = 1, the filtered level is forced to 0.
- R9: With window enable [14] = 1 and `window_in` low, the filtered level holds its previous value and no edge is flagged.
- R10: A rising edge of the filtered level sets flag [26], and a falling edge sets flag [25]. Each flag stays set until a write with a 1 in its bit. An edge in the same cycle as that write leaves the flag set.
- R11: `irq` is high while (flag [25] and enable [27]) or (flag [26] and enable [28]).
- R12: While enable [8] is 0, the filtered level and `cmp_out` are 0 and no flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_in | input | 1 | Comparator decision bit, synchronous to clk |
| sample_strobe | input | 1 | External sample pacing signal, asynchronous |
| window_in | input | 1 | Window gate, high means the filter may update |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| cmp_out | output | 1 | Selected comparator output |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives glitch trains into the counting filter: runs of N-1 agreeing samples broken by one opposite sample. A filter that did not restart its run count on disagreement would switch early. A strobe held high for many clocks must count as one sample; a level-sensitive pacer would let the output switch at once. A three-clock input pulse under a period of three must not get through a two-sample filter; a prescaler that ignored the period would let it through. The bench also covers the forced-low combination, window hold with an edge that must appear only on release, and a clear that arrives in the same cycle as a new edge, which a clear-wins flag would lose.

// File: rtl/cmp_fe_pkg.sv
package cmp_fe_pkg;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned CNT_W  = 3;
   localparam int unsigned PER_W  = 8;

   // bit positions of the control word
   localparam int unsigned B_HYS   = 0;
   localparam int unsigned B_CNT   = 4;
   localparam int unsigned B_EN    = 8;
   localparam int unsigned B_PIN   = 9;
   localparam int unsigned B_SEL   = 10;
   localparam int unsigned B_INV   = 11;
   localparam int unsigned B_PWR   = 12;
   localparam int unsigned B_WIN   = 14;
   localparam int unsigned B_STB   = 15;
   localparam int unsigned B_PER   = 16;
   localparam int unsigned B_LVL   = 24;
   localparam int unsigned B_FFALL = 25;
   localparam int unsigned B_FRISE = 26;
   localparam int unsigned B_IFALL = 27;
   localparam int unsigned B_IRISE = 28;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_PASS  = 2'd1,
      MODE_ZERO  = 2'd2,
      MODE_COUNT = 2'd3
   } flt_mode_e;

   typedef struct packed {
      logic [1:0]       hys;
      logic [CNT_W-1:0] cnt;
      logic             en;
      logic             pin;
      logic             sel;
      logic             inv;
      logic             pwr;
      logic             win;
      logic             stb;
      logic [PER_W-1:0] per;
      logic             ie_fall;
      logic             ie_rise;
   } cfg_t;
endpackage

// File: rtl/cmp_fe_regs.sv
module cmp_fe_regs
   import cmp_fe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              level,
   input  logic              rise_evt,
   input  logic              fall_evt,
   output cfg_t              cfg,
   output logic [WORD_W-1:0] rdata,
   output logic              irq
);
   logic flag_rise, flag_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (wr) begin
         cfg.hys     <= wdata[B_HYS +: 2];
         cfg.cnt     <= wdata[B_CNT +: CNT_W];
         cfg.en      <= wdata[B_EN];
         cfg.pin     <= wdata[B_PIN];
         cfg.sel     <= wdata[B_SEL];
         cfg.inv     <= wdata[B_INV];
         cfg.pwr     <= wdata[B_PWR];
         cfg.win     <= wdata[B_WIN];
         cfg.stb     <= wdata[B_STB];
         cfg.per     <= wdata[B_PER +: PER_W];
         cfg.ie_fall <= wdata[B_IFALL];
         cfg.ie_rise <= wdata[B_IRISE];
      end
   end

   // sticky flags: a new edge wins over a concurrent clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_rise <= 1'b0;
         flag_fall <= 1'b0;
      end else begin
         flag_rise <= (flag_rise & ~(wr & wdata[B_FRISE])) | rise_evt;
         flag_fall <= (flag_fall & ~(wr & wdata[B_FFALL])) | fall_evt;
      end
   end

   always_comb begin
      rdata                 = '0;
      rdata[B_HYS +: 2]     = cfg.hys;
      rdata[B_CNT +: CNT_W] = cfg.cnt;
      rdata[B_EN]           = cfg.en;
      rdata[B_PIN]          = cfg.pin;
      rdata[B_SEL]          = cfg.sel;
      rdata[B_INV]          = cfg.inv;
      rdata[B_PWR]          = cfg.pwr;
      rdata[B_WIN]          = cfg.win;
      rdata[B_STB]          = cfg.stb;
      rdata[B_PER +: PER_W] = cfg.per;
      rdata[B_LVL]          = level;
      rdata[B_FFALL]        = flag_fall;
      rdata[B_FRISE]        = flag_rise;
      rdata[B_IFALL]        = cfg.ie_fall;
      rdata[B_IRISE]        = cfg.ie_rise;
   end

   assign irq = (flag_fall & cfg.ie_fall) | (flag_rise & cfg.ie_rise);
endmodule

// File: rtl/cmp_fe_pacer.sv
module cmp_fe_pacer
   import cmp_fe_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             presc_en,
   input  logic             ext_en,
   input  logic [PER_W-1:0] period,
   input  logic             strobe,
   output logic             tick
);
   logic [PER_W-1:0] div_q;
   logic             strobe_s;
   logic             strobe_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_q <= '0;
      else if (!presc_en)        div_q <= '0;
      else if (div_q == period)  div_q <= '0;
      else                       div_q <= div_q + 1'b1;
   end

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign strobe_s = strobe;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], strobe};
         end
         assign strobe_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_d <= 1'b0;
      else        strobe_d <= strobe_s;
   end

   always_comb begin
      if (presc_en)    tick = (div_q == period);
      else if (ext_en) tick = strobe_s & ~strobe_d;
      else             tick = 1'b0;
   end
endmodule

// File: rtl/cmp_fe_filter.sv
module cmp_fe_filter
   import cmp_fe_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  flt_mode_e         mode,
   input  logic [CNT_W-1:0]  need,
   input  logic              hold,
   input  logic              din,
   input  logic              tick,
   output logic              level,
   output logic              rise_evt,
   output logic              fall_evt
);
   logic             lvl_q, prev_q, last_q;
   logic [CNT_W-1:0] run_q, run_nx;
   logic             live;

   always_comb begin
      if (run_q != '0 && din == last_q)
         run_nx = (run_q == {CNT_W{1'b1}}) ? run_q : run_q + 1'b1;
      else
         run_nx = {{(CNT_W-1){1'b0}}, 1'b1};
   end

   always_comb begin
      unique case (mode)
         MODE_PASS:  live = din;
         MODE_COUNT: live = lvl_q;
         default:    live = 1'b0;
      endcase
   end

   assign level = (mode == MODE_OFF) ? 1'b0 : (hold ? prev_q : live);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b0;
         last_q <= 1'b0;
         run_q  <= '0;
      end else if (mode == MODE_OFF) begin
         lvl_q  <= 1'b0;
         last_q <= 1'b0;
         run_q  <= '0;
      end else if (mode != MODE_COUNT) begin
         lvl_q  <= level;
         run_q  <= '0;
      end else if (tick && !hold) begin
         last_q <= din;
         run_q  <= run_nx;
         if (run_nx >= need) lvl_q <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level;
   end

   assign rise_evt = (mode != MODE_OFF) &  level & ~prev_q;
   assign fall_evt = (mode != MODE_OFF) & ~level &  prev_q;
endmodule

// File: rtl/cmp_backend.sv
module cmp_backend
   import cmp_fe_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              raw_in,
   input  logic              sample_strobe,
   input  logic              window_in,
   input  logic              reg_wr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              cmp_out,
   output logic              irq
);
   localparam int unsigned MAX_SYNC = 4;

   generate
      if (SYNC_STAGES == 1 || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("cmp_backend: SYNC_STAGES must be 0 or 2..%0d", MAX_SYNC);
      end
   endgenerate

   cfg_t      cfg;
   flt_mode_e mode;
   logic      unf, level, rise_evt, fall_evt, tick, hold;

   assign unf = raw_in ^ cfg.inv;

   always_comb begin
      if (!cfg.en)                          mode = MODE_OFF;
      else if (cfg.cnt == '0)               mode = cfg.stb ? MODE_ZERO : MODE_PASS;
      else if (!cfg.stb && cfg.per == '0)   mode = MODE_PASS;
      else                                  mode = MODE_COUNT;
   end

   assign hold = cfg.en & cfg.win & ~window_in;

   cmp_fe_regs u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .level    (level),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .cfg      (cfg),
      .rdata    (reg_rdata),
      .irq      (irq)
   );

   cmp_fe_pacer #(.SYNC_STAGES(SYNC_STAGES)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .presc_en (mode == MODE_COUNT && !cfg.stb),
      .ext_en   (mode == MODE_COUNT && cfg.stb),
      .period   (cfg.per),
      .strobe   (sample_strobe),
      .tick     (tick)
   );

   cmp_fe_filter u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .need     (cfg.cnt),
      .hold     (hold),
      .din      (unf),
      .tick     (tick),
      .level    (level),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   assign cmp_out = cfg.en ? (cfg.sel ? unf : level) : 1'b0;
endmodule

// File: rtl/cmp_fe_checker.sv
module cmp_fe_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        raw_in,
   input logic        window_in,
   input logic        reg_wr,
   input logic [31:0] reg_wdata,
   input logic [31:0] reg_rdata,
   input logic        cmp_out
);
   logic seen_clk;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_clk <= 1'b0;
      else        seen_clk <= 1'b1;
   end

   assert_disabled_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[8] |-> (!cmp_out && !reg_rdata[24]));

   assert_unfiltered_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[8] && reg_rdata[10]) |-> (cmp_out == (raw_in ^ reg_rdata[11])));

   assert_forced_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[8] && reg_rdata[6:4] == 3'd0 && reg_rdata[15] && !reg_rdata[14])
      |-> !reg_rdata[24]);

   assert_window_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_clk && reg_rdata[8] && reg_rdata[14] && !window_in)
      |-> (reg_rdata[24] == $past(reg_rdata[24])));

   assert_rise_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_clk && reg_rdata[8] && reg_rdata[24] && !$past(reg_rdata[24]))
      |=> reg_rdata[26]);

   assert_fall_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_clk && reg_rdata[8] && !reg_rdata[24] && $past(reg_rdata[24]))
      |=> reg_rdata[25]);

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[26] && !(reg_wr && reg_wdata[26])) |=> reg_rdata[26]);
endmodule

bind cmp_backend cmp_fe_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .raw_in    (raw_in),
   .window_in (window_in),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .cmp_out   (cmp_out)
);

// File: tb/test_cmp_backend.sv
`timescale 1ns/1ps
module test_cmp_backend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        raw_in = 1'b0;
   logic        sample_strobe = 1'b0;
   logic        window_in = 1'b1;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cmp_out;
   logic        irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   cmp_backend i_cmp_backend (
      .clk(clk), .rst_n(rst_n), .raw_in(raw_in), .sample_strobe(sample_strobe),
      .window_in(window_in), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cmp_out(cmp_out), .irq(irq)
   );

   // kinds: 0 = cmp_out, 1 = irq, 2 = whole word, 3 = one word bit
   typedef struct {
      string       tag;
      int          kind;
      int          pos;
      logic [31:0] exp;
   } item_t;
   item_t sb_q[$];

   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         case (it.kind)
            0:       act = {31'd0, cmp_out};
            1:       act = {31'd0, irq};
            2:       act = reg_rdata;
            default: act = {31'd0, reg_rdata[it.pos]};
         endcase
         n_checks++;
         if (act !== it.exp) begin
            n_fails++;
            $display("FAIL %s: kind %0d bit %0d actual %h expected %h",
                     it.tag, it.kind, it.pos, act, it.exp);
         end
      end
   end

   task automatic expect_item(string tag, int kind, int pos, logic [31:0] exp);
      item_t it;
      it.tag = tag; it.kind = kind; it.pos = pos; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic settle();
      @(negedge clk); #1;
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [31:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      step(1);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse();
      sample_strobe = 1'b1; step(1);
      sample_strobe = 1'b0; step(4);
   endtask

   function automatic logic [31:0] ctl(bit en, int cnt, bit sel, bit inv,
                                       bit win, bit stb, int per, bit ief, bit ier);
      logic [31:0] w;
      w = '0;
      w[8] = en; w[6:4] = cnt[2:0]; w[10] = sel; w[11] = inv;
      w[14] = win; w[15] = stb; w[23:16] = per[7:0]; w[27] = ief; w[28] = ier;
      return w;
   endfunction

   localparam logic [31:0] CLR = 32'h0600_0000;

   initial begin
      #200000;
      if (!done) begin
         n_checks++; n_fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] c;
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      expect_item("R1", 2, 0, 32'h0);
      expect_item("R1", 0, 0, 0);
      expect_item("R1", 1, 0, 0);
      settle();

      // R2 field storage, R3 invert, R4 unfiltered select (window closed holds level 0)
      window_in = 1'b0;
      wr(32'hFFFF_FFFF);
      expect_item("R2", 2, 0, 32'h18FF_DF73);
      expect_item("R3_R4", 0, 0, 1);
      settle();
      wr(32'h0); wr(CLR);
      window_in = 1'b1;

      // R5 combinational pass-through
      c = ctl(1, 0, 0, 0, 0, 0, 0, 0, 0);
      wr(c);
      raw_in = 1'b1;
      expect_item("R5", 0, 0, 1);
      expect_item("R5", 3, 24, 1);
      settle();
      step(1);
      raw_in = 1'b0;
      step(2);
      // R10 both flags, R11 no irq while disabled
      expect_item("R10", 3, 26, 1);
      expect_item("R10", 3, 25, 1);
      expect_item("R11", 1, 0, 0);
      settle();
      wr(c | 32'h0400_0000);
      expect_item("R10_clear", 3, 26, 0);
      expect_item("R10_keep", 3, 25, 1);
      settle();
      wr(c | 32'h0800_0000);
      expect_item("R11", 1, 0, 1);
      settle();
      wr(c | CLR);
      expect_item("R11", 1, 0, 0);
      settle();

      // R5 period zero with nonzero count is pass-through
      wr(ctl(1, 3, 0, 0, 0, 0, 0, 0, 0));
      raw_in = 1'b1;
      expect_item("R5_per0", 0, 0, 1);
      settle();
      raw_in = 1'b0;
      step(2);

      // R3 invert on the filter path
      wr(ctl(1, 0, 0, 1, 0, 0, 0, 0, 0));
      expect_item("R3", 0, 0, 1);
      settle();
      wr(32'h0); wr(CLR);

      // R6 counting filter paced by external strobe, N = 3
      wr(ctl(1, 3, 0, 0, 0, 1, 0, 0, 0));
      raw_in = 1'b1;
      sample_strobe = 1'b1; step(10); sample_strobe = 1'b0; step(4);
      expect_item("R6_held_strobe", 0, 0, 0);
      settle();
      pulse();
      expect_item("R6_two", 0, 0, 0);
      settle();
      pulse();
      expect_item("R6_three", 0, 0, 1);
      settle();
      raw_in = 1'b0; pulse(); pulse();
      expect_item("R6_glitch", 0, 0, 1);
      settle();
      raw_in = 1'b1; pulse();
      raw_in = 1'b0; pulse(); pulse();
      expect_item("R6_restart", 0, 0, 1);
      settle();
      pulse();
      expect_item("R6_fall", 0, 0, 0);
      settle();
      wr(32'h0); wr(CLR);

      // R7 prescaler pacing, period 3, N = 2
      wr(ctl(1, 2, 0, 0, 0, 0, 3, 0, 0));
      step(10);
      raw_in = 1'b1; step(3); raw_in = 1'b0;
      step(20);
      expect_item("R7_short_pulse", 0, 0, 0);
      settle();
      raw_in = 1'b1; step(3);
      expect_item("R7_early", 0, 0, 0);
      settle();
      step(12);
      expect_item("R7_late", 0, 0, 1);
      settle();
      raw_in = 1'b0;
      wr(32'h0); wr(CLR);

      // R8 forced low, unfiltered still visible through select
      wr(ctl(1, 0, 0, 0, 0, 1, 0, 0, 0));
      raw_in = 1'b1;
      expect_item("R8", 0, 0, 0);
      expect_item("R8", 3, 24, 0);
      settle();
      wr(ctl(1, 0, 1, 0, 0, 1, 0, 0, 0));
      expect_item("R8_R4", 0, 0, 1);
      settle();
      raw_in = 1'b0;
      wr(32'h0); wr(CLR);

      // R9 window hold
      c = ctl(1, 0, 0, 0, 1, 0, 0, 0, 0);
      wr(c);
      raw_in = 1'b1; step(2);
      wr(c | CLR);
      expect_item("R9_open", 0, 0, 1);
      settle();
      window_in = 1'b0; raw_in = 1'b0; step(2);
      expect_item("R9_held", 0, 0, 1);
      expect_item("R9_noflag", 3, 25, 0);
      settle();
      window_in = 1'b1;
      expect_item("R9_release", 0, 0, 0);
      settle();
      step(1);
      expect_item("R9_edge", 3, 25, 1);
      settle();
      wr(32'h0); wr(CLR);

      // R12 disabled block
      wr(ctl(0, 0, 1, 0, 0, 0, 0, 1, 1));
      raw_in = 1'b1; step(2);
      expect_item("R12", 0, 0, 0);
      expect_item("R12", 3, 24, 0);
      expect_item("R12", 3, 26, 0);
      expect_item("R12", 1, 0, 0);
      settle();
      raw_in = 1'b0;
      wr(32'h0);

      // R10 set wins over a clear in the same cycle
      c = ctl(1, 0, 0, 0, 0, 0, 0, 0, 0);
      wr(c);
      raw_in = 1'b1;
      reg_wr = 1'b1; reg_wdata = c | 32'h0400_0000;
      step(1);
      reg_wr = 1'b0; reg_wdata = '0;
      expect_item("R10_set_wins", 3, 26, 1);
      settle();

      done = 1'b1;
      step(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule